// File: doc/BRIEF.md
# Burstable Bus Slave Memory

This block answers transfers on a parallel master/slave bus from a small internal array. When the master signals a transfer start, the slave latches the address, the direction and whether a burst was asked for. It then serves one data beat at a time. Each beat waits out a programmable number of wait states and then ends with a one-clock transfer acknowledge. Read data is driven during the acknowledge clock. Write data is taken at the clock edge that closes it.

During a burst the slave works out each later address itself. It steps the low bits of its own unit index and never crosses the aligned burst block (four or eight words, set by a parameter). The master keeps a burst going by holding a "more data" strobe high during a beat. A configuration input can make the slave non-burstable. A burst request is then answered with a single beat that carries a burst-inhibit flag beside the acknowledge, and the master is expected to fetch the rest with single transfers. The data port width (8, 16 or 32 bits) is a parameter and sets the size of one addressed unit.

Top module: `burst_slave_mem`

## Requirements
- R1: After reset, `ta_o` and `bi_o` are low and array unit i (a unit is PORT_W/8 bytes, indexed by the byte address divided by the unit size) holds the value i XOR a word made of repeated 0x5A bytes.
- R2: When `ts_i` is sampled high at an edge E0 while idle, with wait setting W (`wait_cfg_i`, latched at E0), the first beat's `ta_o` is high exactly during the clock that starts at edge E0+W.
- R3: On a write beat, `wdata_i` is stored into the current unit at the edge that ends the acknowledge clock, and a later read of that unit returns it.
- R4: With `inhibit_i` low at start, a burst (`burst_i` high) keeps `bi_o` low on every beat, and beat k serves unit (start unit + k).
- R5: A burst never leaves the aligned block of BURST_WORDS*4 bytes: the beat at the last unit of that block is the final one, even when `bdip_i` is high.
- R6: A burst ends after the first acknowledged beat during which `bdip_i` is low.
- R7: With `inhibit_i` high at start, a burst request gets exactly one beat, on which `bi_o` is high together with `ta_o`, and only the first addressed unit is read or written.
- R8: With `inhibit_i` high, a single transfer (`burst_i` low) gets one normal beat with `bi_o` low.
- R9: `ta_o` is high for one clock per beat, and a later beat of a burst comes W clocks after the previous acknowledge (back to back when W is 0).
- R10: A `ts_i` pulse that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_i | input | 1 | Transfer start, one clock |
| burst_i | input | 1 | Burst requested, sampled with `ts_i` |
| wr_i | input | 1 | 1 = write, 0 = read, sampled with `ts_i` |
| addr_i | input | AW | Byte address, sampled with `ts_i` |
| wdata_i | input | PORT_W | Write data for the current beat |
| bdip_i | input | 1 | Master will run another beat after this one |
| inhibit_i | input | 1 | 1 = act as a non-burstable slave, sampled with `ts_i` |
| wait_cfg_i | input | WAIT_W | Wait states per beat, sampled with `ts_i` |
| rdata_o | output | PORT_W | Read data, valid while `ta_o` is high |
| ta_o | output | 1 | Transfer acknowledge, one clock per beat |
| bi_o | output | 1 | Burst inhibit, only with `ta_o` |

## Verification
The bench starts bursts at the first unit of a block and partway into one, so that a slave that wraps or runs past the block edge returns wrong data or one beat too many. It drops `bdip_i` early to catch a slave that keeps acknowledging anyway. It asks for a burst from the non-burstable configuration while still holding `bdip_i` high. There a wrong design gives more than one beat, leaves out the inhibit flag or writes units next to the first. It varies the wait count from zero to three, where an off-by-one latency moves the acknowledge by a clock. It also pulses a second start in the middle of a burst, where a slave that reloads its address would serve the wrong units.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } bsm_state_e;

endpackage

// File: rtl/bsm_wait_ctr.sv
module bsm_wait_ctr #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    output logic              zero_o
);

    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bsm_addr_step.sv
module bsm_addr_step #(
    parameter int IDX_W = 4,
    parameter int BW    = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_nx_o,
    output logic             at_end_o
);

    logic [BW-1:0] lo_nx;

    // only the in-block bits advance; the block number is held
    assign lo_nx    = idx_i[BW-1:0] + 1'b1;
    assign at_end_o = &idx_i[BW-1:0];

    if (IDX_W > BW) begin : g_blocked
        assign idx_nx_o = {idx_i[IDX_W-1:BW], lo_nx};
    end else begin : g_single_block
        assign idx_nx_o = lo_nx;
    end

endmodule

// File: rtl/bsm_mem.sv
module bsm_mem #(
    parameter int PORT_W = 32,
    parameter int UNITS  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [PORT_W-1:0] wdata_i,
    output logic [PORT_W-1:0] rdata_o
);

    localparam int UNIT_B = PORT_W / 8;

    logic [PORT_W-1:0] mem_d [UNITS];
    logic [PORT_W-1:0] mem_q [UNITS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < UNITS; i++) begin
                mem_q[i] <= PORT_W'(i) ^ {UNIT_B{8'h5A}};
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/burst_slave_mem.sv
module burst_slave_mem #(
    parameter int PORT_W      = 32,
    parameter int MEM_WORDS   = 16,
    parameter int BURST_WORDS = 4,
    parameter int WAIT_W      = 3,
    localparam int AW         = $clog2(MEM_WORDS * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_i,
    input  logic              burst_i,
    input  logic              wr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [PORT_W-1:0] wdata_i,
    input  logic              bdip_i,
    input  logic              inhibit_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    output logic [PORT_W-1:0] rdata_o,
    output logic              ta_o,
    output logic              bi_o
);

    import bsm_pkg::*;

    localparam int UNIT_B = PORT_W / 8;
    localparam int UB_W   = (UNIT_B > 1) ? $clog2(UNIT_B) : 0;
    localparam int UNITS  = MEM_WORDS * 4 / UNIT_B;
    localparam int IDX_W  = $clog2(UNITS);
    localparam int BEATS  = BURST_WORDS * 4 / UNIT_B;
    localparam int BW     = $clog2(BEATS);

    typedef struct packed {
        bsm_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              wr;
        logic              burst;
        logic              inhib;
        logic [WAIT_W-1:0] wv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              busy;
    logic              inhib_q;
    logic              cnt_zero;
    logic              cnt_load;
    logic [WAIT_W-1:0] cnt_val;
    logic [IDX_W-1:0]  idx_nx;
    logic              at_end;
    logic              beat;
    logic              last_beat;
    logic              mem_we;
    logic [IDX_W-1:0]  start_idx;

    assign busy      = (ctl_q.st == ST_DATA);
    assign inhib_q   = ctl_q.inhib;
    assign beat      = busy && cnt_zero;
    assign start_idx = IDX_W'(addr_i >> UB_W);
    assign last_beat = !ctl_q.burst || ctl_q.inhib || !bdip_i || at_end;

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_val  = ctl_q.wv;
        mem_we   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ts_i) begin
                    ctl_d.st    = ST_DATA;
                    ctl_d.idx   = start_idx;
                    ctl_d.wr    = wr_i;
                    ctl_d.burst = burst_i;
                    ctl_d.inhib = inhibit_i;
                    ctl_d.wv    = wait_cfg_i;
                    cnt_load    = 1'b1;
                    cnt_val     = wait_cfg_i;
                end
            end
            ST_DATA: begin
                if (beat) begin
                    mem_we = ctl_q.wr;
                    if (last_beat) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.idx = idx_nx;
                        cnt_load  = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, wr: 1'b0, burst: 1'b0,
                       inhib: 1'b0, wv: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bsm_wait_ctr #(
        .WAIT_W (WAIT_W)
    ) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .zero_o     (cnt_zero)
    );

    bsm_addr_step #(
        .IDX_W (IDX_W),
        .BW    (BW)
    ) u_step (
        .idx_i    (ctl_q.idx),
        .idx_nx_o (idx_nx),
        .at_end_o (at_end)
    );

    bsm_mem #(
        .PORT_W (PORT_W),
        .UNITS  (UNITS),
        .IDX_W  (IDX_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .idx_i   (ctl_q.idx),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    assign ta_o = beat;
    assign bi_o = beat && ctl_q.burst && inhib_q;

endmodule

// File: rtl/bsm_chk.sv
module bsm_chk (
    input logic clk,
    input logic rst_n,
    input logic ts_i,
    input logic bdip_i,
    input logic ta_o,
    input logic bi_o,
    input logic busy,
    input logic at_end,
    input logic inhib_q
);

    p_bi_with_ta_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bi_o |-> ta_o);

    p_bi_single_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bi_o |=> !ta_o);

    p_no_bi_burstable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_o && !inhib_q) |-> !bi_o);

    p_stop_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_o && at_end) |=> !ta_o);

    p_stop_on_bdip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_o && !bdip_i) |=> !ta_o);

    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ts_i) |=> busy);

    p_ta_inside_txn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |-> busy);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ta_o) |=> busy);

endmodule

bind burst_slave_mem bsm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ts_i    (ts_i),
    .bdip_i  (bdip_i),
    .ta_o    (ta_o),
    .bi_o    (bi_o),
    .busy    (busy),
    .at_end  (at_end),
    .inhib_q (inhib_q)
);

// File: tb/burst_slave_mem_tb_top.sv
module burst_slave_mem_tb_top;

    localparam int PW    = 32;
    localparam int NU    = 16;
    localparam int BLK   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ts_i = 1'b0;
    logic          burst_i = 1'b0;
    logic          wr_i = 1'b0;
    logic [5:0]    addr_i = '0;
    logic [PW-1:0] wdata_i = '0;
    logic          bdip_i = 1'b0;
    logic          inhibit_i = 1'b0;
    logic [2:0]    wait_cfg_i = '0;
    logic [PW-1:0] rdata_o;
    logic          ta_o;
    logic          bi_o;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic [PW-1:0] model [NU];

    always #5 clk = ~clk;

    burst_slave_mem dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts_i       (ts_i),
        .burst_i    (burst_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .bdip_i     (bdip_i),
        .inhibit_i  (inhibit_i),
        .wait_cfg_i (wait_cfg_i),
        .rdata_o    (rdata_o),
        .ta_o       (ta_o),
        .bi_o       (bi_o)
    );

    typedef struct packed {
        logic       wr;
        logic       burst;
        logic       inhib;
        logic [2:0] w;
        logic [3:0] unit;
        logic [3:0] want;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 3'd0, 4'd5,  4'd1},  // R1 R2 single read
        '{1'b1, 1'b0, 1'b0, 3'd1, 4'd6,  4'd1},  // R3 single write
        '{1'b0, 1'b0, 1'b0, 3'd2, 4'd6,  4'd1},  // R3 read back
        '{1'b1, 1'b1, 1'b0, 3'd0, 4'd8,  4'd4},  // R4 full burst write
        '{1'b0, 1'b1, 1'b0, 3'd1, 4'd8,  4'd4},  // R4 R9 full burst read
        '{1'b0, 1'b1, 1'b0, 3'd0, 4'd9,  4'd4},  // R5 stops at edge
        '{1'b1, 1'b1, 1'b0, 3'd0, 4'd13, 4'd4},  // R5 write to edge
        '{1'b0, 1'b1, 1'b0, 3'd1, 4'd12, 4'd2},  // R6 early end
        '{1'b1, 1'b1, 1'b1, 3'd0, 4'd2,  4'd4},  // R7 inhibited write
        '{1'b0, 1'b1, 1'b0, 3'd0, 4'd0,  4'd4},  // R7 neighbours intact
        '{1'b0, 1'b0, 1'b1, 3'd1, 4'd3,  4'd1},  // R8 single, inhibit cfg
        '{1'b0, 1'b1, 1'b0, 3'd3, 4'd12, 4'd4},  // R9 long waits
        '{1'b0, 1'b1, 1'b1, 3'd2, 4'd8,  4'd4}   // R7 inhibited read
    };

    task automatic check(input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] wval(input int seed, input int b);
        return 32'hC0DE_0000 | PW'(seed << 4) | PW'(b);
    endfunction

    task automatic run_txn(input vec_t v, input int seed);
        int nb;
        int room;
        room = BLK - (int'(v.unit) % BLK);
        if (!v.burst || v.inhib) nb = 1;
        else nb = (int'(v.want) < room) ? int'(v.want) : room;
        @(negedge clk);
        ts_i       = 1'b1;
        burst_i    = v.burst;
        wr_i       = v.wr;
        inhibit_i  = v.inhib;
        wait_cfg_i = v.w;
        addr_i     = {v.unit, 2'b00};
        bdip_i     = v.burst && (v.want > 4'd1);
        wdata_i    = wval(seed, 0);
        @(negedge clk);
        ts_i = 1'b0;
        for (int b = 0; b < nb; b++) begin
            int u;
            u = int'(v.unit) + b;
            bdip_i  = v.burst && (b + 1 < int'(v.want));
            wdata_i = wval(seed, b);
            for (int k = 0; k < int'(v.w); k++) begin
                check("R9 ta low during wait", PW'(ta_o), '0);
                @(negedge clk);
            end
            check("R2 R9 ta on beat", PW'(ta_o), 1);
            check("R4 R7 R8 bi flag", PW'(bi_o), PW'(v.burst && v.inhib));
            if (v.wr) model[u] = wval(seed, b);
            else check("R3 R4 R5 read data", rdata_o, model[u]);
            @(negedge clk);
        end
        bdip_i = 1'b0;
        for (int k = 0; k <= int'(v.w) + 1; k++) begin
            check("R5 R6 R7 no extra beat", PW'(ta_o), '0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NU; i++) model[i] = PW'(i) ^ 32'h5A5A_5A5A;
        repeat (3) @(negedge clk);
        check("R1 ta after reset", PW'(ta_o), '0);
        check("R1 bi after reset", PW'(bi_o), '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_txn(VEC[i], i);

        // R10: second start during a burst is ignored
        @(negedge clk);
        ts_i = 1'b1; burst_i = 1'b1; wr_i = 1'b0; inhibit_i = 1'b0;
        wait_cfg_i = 3'd2; addr_i = {4'd4, 2'b00}; bdip_i = 1'b1;
        @(negedge clk);
        ts_i = 1'b1; burst_i = 1'b0; addr_i = {4'd0, 2'b00};
        @(negedge clk);
        ts_i = 1'b0;
        check("R10 still waiting", PW'(ta_o), '0);
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            bdip_i = (b < 3);
            check("R10 beat present", PW'(ta_o), 1);
            check("R10 original units", rdata_o, model[4 + b]);
            @(negedge clk);
            if (b < 3) begin
                check("R10 gap", PW'(ta_o), '0);
                @(negedge clk);
                @(negedge clk);
            end
        end
        check("R10 burst over", PW'(ta_o), '0);

        // R1: reset during a burst clears the beat and the array
        @(negedge clk);
        ts_i = 1'b1; burst_i = 1'b1; wr_i = 1'b0; wait_cfg_i = 3'd0;
        addr_i = {4'd8, 2'b00}; bdip_i = 1'b1;
        @(negedge clk);
        ts_i = 1'b0;
        check("R1 beat before reset", PW'(ta_o), 1);
        rst_n = 1'b0;
        #1;
        check("R1 ta cleared by reset", PW'(ta_o), '0);
        bdip_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NU; i++) model[i] = PW'(i) ^ 32'h5A5A_5A5A;
        run_txn('{1'b0, 1'b1, 1'b0, 3'd0, 4'd8, 4'd4}, 99);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule